// File: doc/BRIEF.md
# Coprocessor Window Bus Decoder

This block sits between a main CPU and a 32 KB window that maps onto the address space of a secondary 8-bit processor. Each request carries a 15-bit window offset, a read/write flag, a size flag (byte or word) and write data. The two top offset bits pick one of four targets: an 8 KB local RAM in two aliased halves, a four-register FM sound port, a miscellaneous page group holding a one-bit bank-select register, and a reserved page that locks the bus.

All targets are 8 bits wide. A word read makes one byte read and copies that byte onto both halves of the returned word. A word write sends only its upper data byte down the byte path. The RAM and the FM port are reached through strobes in the request cycle. Read results come back one clock later with a valid strobe. Every RAM write reports an eight-cycle access penalty through a one-cycle wait pulse.

The bank register is held inside the block. An access to the reserved page sets a sticky halt flag unless the force-acknowledge input is high. Once halted, the block ignores all requests until reset.

Top module: `cpwin_decoder`

## Requirements
- R1: With offset bits 14:13 equal to 0 or 1, a request drives `ram_en` in the same cycle with `ram_addr` equal to offset bits 12:0, so offsets 0x1FFF and 0x3FFF reach the same byte. A RAM read returns the stored byte with `rd_valid` high one clock after the request.
- R2: With offset bits 14:13 equal to 2, a request drives `fm_strobe` in the same cycle with `fm_index` equal to offset bits 1:0 and `fm_write` equal to the request's write flag. A read returns the `fm_rdata` byte seen in the request cycle.
- R3: A write to page 0x60 (offset bits 14:8 equal to 0x60) stores write-byte bit 0 into `bank_bit` and pulses `bank_strobe`, both visible one clock after the request. A write to any other page of region 3 leaves `bank_bit` unchanged and gives no strobe.
- R4: A read from region 3, on any page other than 0x60 and 0x7F, returns the low byte of `open_bus` ORed with 0xFF, which is 0xFF.
- R5: An access of either kind to page 0x7F while `force_ack` is low sets `halt` one clock later and gives no read response. `halt` stays high until reset.
- R6: While `force_ack` is high, an access to page 0x7F leaves `halt` low, a read there returns the low byte of `open_bus`, and a write there has no effect.
- R7: A word read returns the 8-bit result in both bytes of `rd_data`. A byte read returns it in bits 7:0 with bits 15:8 zero.
- R8: A byte write forwards `req_wdata[7:0]` as the write byte. A word write forwards `req_wdata[15:8]`. This byte goes out on `ram_wdata` and `fm_wdata` and feeds the bank register.
- R9: One clock after a RAM write, `wait_pulse` is high for exactly one cycle with `wait_cycles` equal to 8. No other kind of access raises it.
- R10: While `halt` is high, no request drives `ram_en` or `fm_strobe`, and no request produces `rd_valid`.
- R11: During and right after reset, `halt`, `bank_bit`, `rd_valid`, `wait_pulse` and `bank_strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_ack | input | 1 | When high, reserved-page accesses do not halt |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 15 | Offset inside the window |
| req_wdata | input | 16 | Write data |
| open_bus | input | 16 | Value floating on the CPU bus |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| halt | output | 1 | Sticky bus lock |
| wait_pulse | output | 1 | One-cycle latency report |
| wait_cycles | output | 4 | Penalty cycles carried by the pulse |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte index |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one clock after `ram_en` |
| fm_strobe | output | 1 | FM port access strobe |
| fm_write | output | 1 | FM port write flag |
| fm_index | output | 2 | FM register index |
| fm_wdata | output | 8 | FM write byte |
| fm_rdata | input | 8 | FM read byte, same cycle |
| bank_strobe | output | 1 | Bank register updated |
| bank_bit | output | 1 | Bank-select bit |

## Verification
A vector table drives byte and word reads and writes into each region. It tells the two RAM halves apart from a separate store, and it tells byte replication apart from zero fill. Directed writes with different upper and lower data bytes show which byte is forwarded. Word and byte writes to the bank page carry opposite bit-0 values in their two bytes, and a write to a neighbouring page checks that other pages leave the bank bit alone. The reserved page is hit once with the override on and once with it off, and later RAM and FM requests show that a halted block stays quiet until reset.

// File: rtl/cpwin_pkg.sv
package cpwin_pkg;

   typedef enum logic [2:0] {
      KIND_RAM  = 3'd0,
      KIND_FM   = 3'd1,
      KIND_BANK = 3'd2,
      KIND_LOCK = 3'd3,
      KIND_VOID = 3'd4
   } acc_kind_e;

   function automatic logic [7:0] fold_wdata(input logic is_word, input logic [15:0] d);
      return is_word ? d[15:8] : d[7:0];
   endfunction

endpackage

// File: rtl/cpwin_addr_map.sv
module cpwin_addr_map
   import cpwin_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int RAM_AW = 13,
   parameter int FM_AW  = 2,
   parameter int PAGE_W = 7,
   parameter logic [PAGE_W-1:0] BANK_PAGE = 7'h60,
   parameter logic [PAGE_W-1:0] LOCK_PAGE = 7'h7F
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [RAM_AW-1:0] ram_idx,
   output logic [FM_AW-1:0]  fm_idx
);

   localparam int REGION_W = ADDR_W - RAM_AW;

   if (REGION_W != 2) begin : g_bad_region
      $error("cpwin_addr_map: window must split into four regions");
   end
   if (PAGE_W > ADDR_W) begin : g_bad_page
      $error("cpwin_addr_map: page field wider than address");
   end

   logic [REGION_W-1:0] region;
   logic [PAGE_W-1:0]   page;

   assign region  = addr[ADDR_W-1 -: REGION_W];
   assign page    = addr[ADDR_W-1 -: PAGE_W];
   assign ram_idx = addr[RAM_AW-1:0];
   assign fm_idx  = addr[FM_AW-1:0];

   always_comb begin
      unique case (region)
         2'd0, 2'd1: kind = KIND_RAM;
         2'd2:       kind = KIND_FM;
         default: begin
            if (page == BANK_PAGE)      kind = KIND_BANK;
            else if (page == LOCK_PAGE) kind = KIND_LOCK;
            else                        kind = KIND_VOID;
         end
      endcase
   end

endmodule

// File: rtl/cpwin_resp.sv
module cpwin_resp
   import cpwin_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  acc_kind_e         kind,
   input  logic              is_word,
   input  logic [BYTE_W-1:0] fm_rdata,
   input  logic [BYTE_W-1:0] open_byte,
   input  logic [BYTE_W-1:0] ram_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int LANES = DATA_W / BYTE_W;

   if (LANES * BYTE_W != DATA_W) begin : g_bad_lanes
      $error("cpwin_resp: data width must be a whole number of bytes");
   end

   logic              vld_q;
   logic              from_ram_q;
   logic              word_q;
   logic [BYTE_W-1:0] byte_q;
   logic [BYTE_W-1:0] byte_d;
   logic [BYTE_W-1:0] byte_now;

   always_comb begin
      unique case (kind)
         KIND_FM:   byte_d = fm_rdata;
         KIND_VOID: byte_d = open_byte | {BYTE_W{1'b1}};
         KIND_LOCK: byte_d = open_byte;
         default:   byte_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q      <= 1'b0;
         from_ram_q <= 1'b0;
         word_q     <= 1'b0;
         byte_q     <= '0;
      end else begin
         vld_q <= rd_fire;
         if (rd_fire) begin
            from_ram_q <= (kind == KIND_RAM);
            word_q     <= is_word;
            byte_q     <= byte_d;
         end
      end
   end

   assign byte_now = from_ram_q ? ram_rdata : byte_q;
   assign rd_valid = vld_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_low
         assign rd_data[BYTE_W-1:0] = byte_now;
      end else begin : g_up
         assign rd_data[l*BYTE_W +: BYTE_W] = word_q ? byte_now : '0;
      end
   end

endmodule

// File: rtl/cpwin_ctrl.sv
module cpwin_ctrl #(
   parameter int WAIT_W   = 4,
   parameter int RAM_WAIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_set,
   input  logic              bank_wr,
   input  logic              bank_d,
   input  logic              ram_wr,
   output logic              halt,
   output logic              bank_bit,
   output logic              bank_strobe,
   output logic              wait_pulse,
   output logic [WAIT_W-1:0] wait_cycles
);

   localparam logic [WAIT_W-1:0] WAIT_VAL = WAIT_W'(RAM_WAIT);

   if (RAM_WAIT >= (1 << WAIT_W)) begin : g_bad_wait
      $error("cpwin_ctrl: wait count does not fit its field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt        <= 1'b0;
         bank_bit    <= 1'b0;
         bank_strobe <= 1'b0;
         wait_pulse  <= 1'b0;
         wait_cycles <= '0;
      end else begin
         if (halt_set) halt <= 1'b1;
         bank_strobe <= bank_wr;
         if (bank_wr) bank_bit <= bank_d;
         wait_pulse  <= ram_wr;
         wait_cycles <= ram_wr ? WAIT_VAL : '0;
      end
   end

endmodule

// File: rtl/cpwin_decoder.sv
module cpwin_decoder
   import cpwin_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int RAM_AW   = 13,
   parameter int FM_AW    = 2,
   parameter int BYTE_W   = 8,
   parameter int WAIT_W   = 4,
   parameter int RAM_WAIT = 8,
   parameter bit OPEN_HI  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_ack,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2*BYTE_W-1:0] req_wdata,
   input  logic [2*BYTE_W-1:0] open_bus,
   output logic              rd_valid,
   output logic [2*BYTE_W-1:0] rd_data,
   output logic              halt,
   output logic              wait_pulse,
   output logic [WAIT_W-1:0] wait_cycles,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [BYTE_W-1:0] ram_wdata,
   input  logic [BYTE_W-1:0] ram_rdata,
   output logic              fm_strobe,
   output logic              fm_write,
   output logic [FM_AW-1:0]  fm_index,
   output logic [BYTE_W-1:0] fm_wdata,
   input  logic [BYTE_W-1:0] fm_rdata,
   output logic              bank_strobe,
   output logic              bank_bit
);

   localparam int DATA_W = 2 * BYTE_W;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("cpwin_decoder: targets are byte wide");
   end

   acc_kind_e         kind;
   logic              acc;
   logic              lock_hit;
   logic              halt_set;
   logic              rd_fire;
   logic              bank_wr;
   logic [BYTE_W-1:0] wbyte;
   logic [BYTE_W-1:0] open_byte;

   cpwin_addr_map #(
      .ADDR_W (ADDR_W),
      .RAM_AW (RAM_AW),
      .FM_AW  (FM_AW)
   ) u_map (
      .addr    (req_addr),
      .kind    (kind),
      .ram_idx (ram_addr),
      .fm_idx  (fm_index)
   );

   assign acc       = req_valid && !halt;
   assign lock_hit  = acc && (kind == KIND_LOCK);
   assign halt_set  = lock_hit && !force_ack;
   assign rd_fire   = acc && !req_write && !halt_set;
   assign wbyte     = fold_wdata(req_word, req_wdata);
   assign open_byte = OPEN_HI ? open_bus[DATA_W-1:BYTE_W] : open_bus[BYTE_W-1:0];

   assign ram_en    = acc && (kind == KIND_RAM);
   assign ram_we    = ram_en && req_write;
   assign ram_wdata = wbyte;
   assign fm_strobe = acc && (kind == KIND_FM);
   assign fm_write  = fm_strobe && req_write;
   assign fm_wdata  = wbyte;
   assign bank_wr   = acc && req_write && (kind == KIND_BANK);

   cpwin_resp #(
      .BYTE_W (BYTE_W),
      .DATA_W (DATA_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .kind      (kind),
      .is_word   (req_word),
      .fm_rdata  (fm_rdata),
      .open_byte (open_byte),
      .ram_rdata (ram_rdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   cpwin_ctrl #(
      .WAIT_W   (WAIT_W),
      .RAM_WAIT (RAM_WAIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_set    (halt_set),
      .bank_wr     (bank_wr),
      .bank_d      (wbyte[0]),
      .ram_wr      (ram_we),
      .halt        (halt),
      .bank_bit    (bank_bit),
      .bank_strobe (bank_strobe),
      .wait_pulse  (wait_pulse),
      .wait_cycles (wait_cycles)
   );

endmodule

// File: rtl/cpwin_decoder_chk.sv
module cpwin_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic force_ack,
   input logic req_valid,
   input logic req_write,
   input logic rd_valid,
   input logic halt,
   input logic wait_pulse,
   input logic ram_en,
   input logic ram_we,
   input logic fm_strobe,
   input logic bank_strobe,
   input logic bank_bit
);

   // R1: a read response always follows an accepted read one clock earlier
   p_rd_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write && !halt));

   // R3: the bank bit moves only together with its strobe
   p_bank_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_strobe |-> $stable(bank_bit));

   // R5: halt never clears outside reset
   p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);

   // R6: halt never rises from a cycle with the override set
   p_force_no_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> !$past(force_ack));

   // R9: a wait pulse is always caused by a RAM write in the previous cycle
   p_wait_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wait_pulse |-> $past(ram_we));

   // R10: a halted block drives no target strobe
   p_quiet_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !(ram_en || fm_strobe));

endmodule

bind cpwin_decoder cpwin_decoder_chk u_chk (.*);

// File: tb/cpwin_decoder_tb.sv
module cpwin_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        force_ack = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [14:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] open_bus = 16'h1234;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        halt;
   logic        wait_pulse;
   logic [3:0]  wait_cycles;
   logic        ram_en;
   logic        ram_we;
   logic [12:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = '0;
   logic        fm_strobe;
   logic        fm_write;
   logic [1:0]  fm_index;
   logic [7:0]  fm_wdata;
   logic [7:0]  fm_rdata = 8'h5A;
   logic        bank_strobe;
   logic        bank_bit;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cpwin_decoder u_dut (.*);

   // behavioural synchronous RAM
   logic [7:0] tb_mem [logic [12:0]];
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) tb_mem[ram_addr] = ram_wdata;
         else ram_rdata = tb_mem.exists(ram_addr) ? tb_mem[ram_addr] : 8'h00;
      end
   end

   // captured in request cycle
   logic       c_ram_en, c_ram_we, c_fm, c_fm_w;
   logic [12:0] c_ram_addr;
   logic [7:0] c_ram_wd, c_fm_wd;
   logic [1:0] c_fm_idx;
   // captured one clock later
   logic       o_rd_valid, o_wait, o_bank_stb, o_bank, o_halt;
   logic [15:0] o_rd_data;
   logic [3:0] o_wait_n;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic wd, input logic [14:0] a, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
      #1;
      c_ram_en = ram_en; c_ram_we = ram_we; c_ram_addr = ram_addr; c_ram_wd = ram_wdata;
      c_fm = fm_strobe; c_fm_w = fm_write; c_fm_idx = fm_index; c_fm_wd = fm_wdata;
      @(negedge clk);
      o_rd_valid = rd_valid; o_rd_data = rd_data; o_wait = wait_pulse; o_wait_n = wait_cycles;
      o_bank_stb = bank_strobe; o_bank = bank_bit; o_halt = halt;
      req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
   endtask

   // {write, word, addr[14:0], wdata[15:0], expected read[15:0]}
   localparam int NV = 10;
   localparam logic [48:0] VEC [NV] = '{
      {1'b1, 1'b0, 15'h0010, 16'h00A5, 16'h0000},
      {1'b0, 1'b0, 15'h0010, 16'h0000, 16'h00A5},
      {1'b1, 1'b1, 15'h2020, 16'h3C99, 16'h0000},
      {1'b0, 1'b1, 15'h2020, 16'h0000, 16'h3C3C},
      {1'b0, 1'b0, 15'h4001, 16'h0000, 16'h005A},
      {1'b0, 1'b1, 15'h4003, 16'h0000, 16'h5A5A},
      {1'b0, 1'b0, 15'h6123, 16'h0000, 16'h00FF},
      {1'b0, 1'b1, 15'h6200, 16'h0000, 16'hFFFF},
      {1'b1, 1'b0, 15'h1FFF, 16'h0077, 16'h0000},
      {1'b0, 1'b0, 15'h3FFF, 16'h0000, 16'h0077}
   };

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      chk(!halt && !bank_bit && !rd_valid && !wait_pulse && !bank_strobe, "R11 in reset",
          {halt, bank_bit, rd_valid, wait_pulse, bank_strobe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!halt && !bank_bit && !rd_valid && !wait_pulse, "R11 after reset",
          {halt, bank_bit, rd_valid, wait_pulse}, 0);

      // table walk: R1 R2 R4 R7
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][48], VEC[i][47], VEC[i][46:32], VEC[i][31:16]);
         if (!VEC[i][48]) begin
            chk(o_rd_valid, "R1 table rd_valid", o_rd_valid, 1);
            chk(o_rd_data == VEC[i][15:0], VEC[i][47] ? "R7 table word read" :
                (VEC[i][46:45] == 2'd2 ? "R2 table fm read" :
                 (VEC[i][46:45] == 2'd3 ? "R4 table misc read" : "R1 table ram read")),
                o_rd_data, VEC[i][15:0]);
         end
      end

      // R1 strobes, R8 byte write, R9 wait pulse
      access(1'b1, 1'b0, 15'h0155, 16'hEE42);
      chk(c_ram_en && c_ram_we && c_ram_addr == 13'h0155, "R1 ram strobe", {c_ram_we, c_ram_addr}, 16'h2155);
      chk(c_ram_wd == 8'h42, "R8 byte write lower", c_ram_wd, 8'h42);
      chk(o_wait && o_wait_n == 4'd8, "R9 wait pulse", {o_wait, o_wait_n}, 5'h18);
      @(negedge clk);
      chk(!wait_pulse, "R9 pulse one cycle", wait_pulse, 0);

      // R2 FM write, R8 word folding
      access(1'b1, 1'b1, 15'h4002, 16'hAB12);
      chk(c_fm && c_fm_w && c_fm_idx == 2'd2, "R2 fm strobe", {c_fm, c_fm_w, c_fm_idx}, 4'hE);
      chk(c_fm_wd == 8'hAB, "R8 word write upper", c_fm_wd, 8'hAB);
      chk(!o_wait, "R9 no wait on fm", o_wait, 0);
      access(1'b1, 1'b0, 15'h5FFD, 16'h11CD);
      chk(c_fm_idx == 2'd1 && c_fm_wd == 8'hCD, "R2 fm index byte", {c_fm_idx, c_fm_wd}, 10'h1CD);

      // R3 bank register
      access(1'b1, 1'b0, 15'h6000, 16'h0001);
      chk(o_bank_stb && o_bank, "R3 bank set", {o_bank_stb, o_bank}, 2'b11);
      access(1'b1, 1'b0, 15'h6155, 16'h0000);
      chk(!o_bank_stb && o_bank, "R3 other page ignored", {o_bank_stb, o_bank}, 2'b01);
      access(1'b1, 1'b1, 15'h60FF, 16'h00FF);
      chk(o_bank_stb && !o_bank, "R3 word bank uses upper byte", {o_bank_stb, o_bank}, 2'b10);

      // R6 override
      force_ack = 1'b1;
      access(1'b0, 1'b0, 15'h7F04, 16'h0000);
      chk(!o_halt && o_rd_valid && o_rd_data == 16'h0034, "R6 forced read",
          {o_halt, o_rd_valid, o_rd_data}, 18'h00034 | 18'h10000);
      access(1'b1, 1'b0, 15'h7F00, 16'h0055);
      chk(!o_halt && !c_ram_en && !c_fm && !o_bank_stb, "R6 forced write ignored",
          {o_halt, c_ram_en, c_fm, o_bank_stb}, 0);
      force_ack = 1'b0;

      // R5 lock
      access(1'b0, 1'b0, 15'h7F10, 16'h0000);
      chk(o_halt && !o_rd_valid, "R5 halt no response", {o_halt, o_rd_valid}, 2'b10);
      repeat (3) @(negedge clk);
      chk(halt, "R5 halt sticky", halt, 1);

      // R10 halted quiet
      access(1'b1, 1'b0, 15'h0001, 16'h0099);
      chk(!c_ram_en && !o_wait, "R10 ram blocked", {c_ram_en, o_wait}, 0);
      access(1'b0, 1'b0, 15'h4000, 16'h0000);
      chk(!c_fm && !o_rd_valid, "R10 fm blocked", {c_fm, o_rd_valid}, 0);

      // R5 reset clears
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!halt && !bank_bit, "R5 reset clears halt", {halt, bank_bit}, 0);

      finish_run();
   end

endmodule